// File: doc/BRIEF.md
# Floating-Point NaN Screening Unit

This unit sits between the operand path and the result path of a floating-point datapath that works on IEEE 754 single and double precision values. Each cycle it may receive one operation: one or two source operands, the result that the arithmetic core produced for them, a precision select and an operation class (arithmetic or transfer). One cycle later it presents the final result. For arithmetic operations, any NaN source causes the core result to be replaced by the default quiet NaN of the chosen precision. A signaling NaN source also sets a sticky invalid-operation flag. Transfers move the first operand through unchanged and never raise the flag.

Single precision values occupy the low 32 bits of each 64-bit bus. The upper half of a single-precision operand is ignored. A single-precision output is zero-extended to 64 bits. The status word holds the invalid flag at bit 0. Software clears it with the write port. Operations can only set it.

Top module: `fp_nan_screen`

## Requirements
- R1: A value is a NaN when its exponent is all ones (8 bits 30:23 for single, 11 bits 62:52 for double) and its fraction is nonzero. It is signaling when the top fraction bit (bit 22 single, bit 51 double) is 0 and quiet when that bit is 1. In single precision, bits 63:32 of an operand are ignored.
- R2: For an arithmetic operation (`xfer_i`=0) with any used source a signaling NaN, `res_o` is the default quiet NaN: 0x000000007FC00000 in single precision, 0x7FF8000000000000 in double. `inv_o` is 1 and status bit 0 becomes 1.
- R3: For an arithmetic operation whose used sources include quiet NaNs but no signaling NaN, `res_o` is the default quiet NaN of the precision, `inv_o` is 0 and the status flag is unchanged.
- R4: For a transfer (`xfer_i`=1), `res_o` equals `op_a_i` bit for bit (double) or `{32'h0, op_a_i[31:0]}` (single), even when it is a signaling NaN. `res_i` is unused and no invalid flag is raised.
- R5: For an arithmetic operation with no NaN among its used sources, including infinities (all-ones exponent, zero fraction), `res_o` equals `res_i` (double) or `{32'h0, res_i[31:0]}` (single).
- R6: Once status bit 0 is set, it stays set through later operations of any kind until a status write with bit 0 equal to 0.
- R7: `sts_we_i` loads `sts_wdata_i[0]` into status bit 0. If an operation sets the flag in the same cycle, the flag ends at 1.
- R8: `out_valid_o`, `res_o` and `inv_o` appear one cycle after `valid_i`. The flag becomes visible on `sts_o[0]` in that same cycle.
- R9: With `b_en_i`=0, operand B has no effect on the result or the flag.
- R10: After reset, `out_valid_o`, `inv_o` and `sts_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | An operation is present |
| dbl_i | input | 1 | 1 selects double precision, 0 selects single |
| xfer_i | input | 1 | 1 for a transfer, 0 for an arithmetic operation |
| b_en_i | input | 1 | Operand B is a used source |
| op_a_i | input | 64 | Source operand A |
| op_b_i | input | 64 | Source operand B |
| res_i | input | 64 | Result from the arithmetic core |
| sts_we_i | input | 1 | Status write strobe |
| sts_wdata_i | input | 32 | Status write data; only bit 0 is stored |
| out_valid_o | output | 1 | Result valid strobe |
| res_o | output | 64 | Screened result |
| inv_o | output | 1 | This operation raised invalid-operation |
| sts_o | output | 32 | Status word; bit 0 is the sticky invalid flag |

## Verification
The assertions check on every cycle that the strobe follows an accepted operation by one cycle, and that a raised invalid always comes with a default-NaN result and a visible status bit. They also check that the flag never drops without a clearing write and that a set request always wins. Only the bench's scenarios can show the classification itself: that infinities and single-precision operands with junk upper bits are not taken for NaNs, that transfers keep payloads bit for bit, and that a disabled operand B is ignored.

// File: rtl/fp_nan_pkg.sv
package fp_nan_pkg;
  localparam int unsigned DATA_W    = 64;
  localparam int unsigned SP_EXP_W  = 8;
  localparam int unsigned SP_FRAC_W = 23;
  localparam int unsigned DP_EXP_W  = 11;
  localparam int unsigned DP_FRAC_W = 52;
  localparam int unsigned SP_W      = 1 + SP_EXP_W + SP_FRAC_W;
  localparam int unsigned STS_W     = 32;

  localparam logic [DATA_W-1:0] DEF_NAN_SP = {{(DATA_W-SP_W){1'b0}}, 1'b0,
                                              {SP_EXP_W{1'b1}}, 1'b1, {(SP_FRAC_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] DEF_NAN_DP = {1'b0, {DP_EXP_W{1'b1}}, 1'b1,
                                              {(DP_FRAC_W-1){1'b0}}};

  typedef struct packed {
    logic is_nan;
    logic is_snan;
  } nan_cls_t;
endpackage

// File: rtl/fp_nan_class.sv
module fp_nan_class #(
  parameter int unsigned EXP_W  = 8,
  parameter int unsigned FRAC_W = 23,
  localparam int unsigned W     = 1 + EXP_W + FRAC_W
) (
  input  logic [W-1:0]         val_i,
  output fp_nan_pkg::nan_cls_t cls_o
);
  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;

  assign exp_f  = val_i[W-2 -: EXP_W];
  assign frac_f = val_i[FRAC_W-1:0];

  always_comb begin
    cls_o.is_nan  = (&exp_f) && (|frac_f);
    cls_o.is_snan = cls_o.is_nan && !frac_f[FRAC_W-1];
  end
endmodule

// File: rtl/fp_nan_flag.sv
module fp_nan_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic we_i,
  input  logic wdata_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;   // set beats software write
    else if (we_i)   flag_o <= wdata_i;
  end

  // R6
  sticky_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_o && !(we_i && !wdata_i) |=> flag_o);
  // R7
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_o);
endmodule

// File: rtl/fp_nan_screen.sv
module fp_nan_screen
  import fp_nan_pkg::*;
#(
  parameter int unsigned N_SRC = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              dbl_i,
  input  logic              xfer_i,
  input  logic              b_en_i,
  input  logic [DATA_W-1:0] op_a_i,
  input  logic [DATA_W-1:0] op_b_i,
  input  logic [DATA_W-1:0] res_i,
  input  logic              sts_we_i,
  input  logic [STS_W-1:0]  sts_wdata_i,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] res_o,
  output logic              inv_o,
  output logic [STS_W-1:0]  sts_o
);
  logic [N_SRC-1:0][DATA_W-1:0] src;
  logic [N_SRC-1:0]             src_en;
  nan_cls_t [N_SRC-1:0]         cls_sp, cls_dp, cls;

  assign src    = {op_b_i, op_a_i};
  assign src_en = {b_en_i, 1'b1};

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    fp_nan_class #(.EXP_W(SP_EXP_W), .FRAC_W(SP_FRAC_W)) u_sp (
      .val_i (src[i][SP_W-1:0]),
      .cls_o (cls_sp[i])
    );
    fp_nan_class #(.EXP_W(DP_EXP_W), .FRAC_W(DP_FRAC_W)) u_dp (
      .val_i (src[i]),
      .cls_o (cls_dp[i])
    );
    assign cls[i] = dbl_i ? cls_dp[i] : cls_sp[i];
  end

  logic any_nan, any_snan, set_inv, subst;
  logic [DATA_W-1:0] res_d;

  function automatic logic [DATA_W-1:0] fit(input logic dbl, input logic [DATA_W-1:0] v);
    return dbl ? v : {{(DATA_W-SP_W){1'b0}}, v[SP_W-1:0]};
  endfunction

  always_comb begin
    any_nan  = 1'b0;
    any_snan = 1'b0;
    for (int i = 0; i < N_SRC; i++) begin
      any_nan  |= src_en[i] && cls[i].is_nan;
      any_snan |= src_en[i] && cls[i].is_snan;
    end
    subst   = !xfer_i && any_nan;
    set_inv = valid_i && !xfer_i && any_snan;
    if (xfer_i)     res_d = fit(dbl_i, op_a_i);
    else if (subst) res_d = dbl_i ? DEF_NAN_DP : DEF_NAN_SP;
    else            res_d = fit(dbl_i, res_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      inv_o       <= 1'b0;
      res_o       <= '0;
    end else begin
      out_valid_o <= valid_i;
      inv_o       <= set_inv;
      if (valid_i) res_o <= res_d;
    end
  end

  logic flag;
  fp_nan_flag u_flag (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (set_inv),
    .we_i    (sts_we_i),
    .wdata_i (sts_wdata_i[0]),
    .flag_o  (flag)
  );
  assign sts_o = {{(STS_W-1){1'b0}}, flag};

  // R8
  strobe_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> out_valid_o);
  // R8
  flag_vis_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_o |-> out_valid_o && sts_o[0]);
  // R2
  inv_dnan_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_o |-> (res_o == DEF_NAN_SP) || (res_o == DEF_NAN_DP));
  // R4
  xfer_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && xfer_i |=> !inv_o);
endmodule

// File: tb/tb_fp_nan_screen.sv
module tb_fp_nan_screen;
  logic clk = 1'b0, rst_n = 1'b0;
  logic valid = 0, dbl = 0, xfer = 0, b_en = 0, we = 0;
  logic [63:0] op_a = '0, op_b = '0, res = '0;
  logic [31:0] wdata = '0;
  logic out_valid, inv;
  logic [63:0] res_out;
  logic [31:0] sts;
  int n_chk = 0, n_fail = 0;

  localparam logic [63:0] DN_SP = 64'h0000_0000_7FC0_0000;
  localparam logic [63:0] DN_DP = 64'h7FF8_0000_0000_0000;

  always #5 clk = ~clk;

  fp_nan_screen dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .dbl_i(dbl), .xfer_i(xfer),
    .b_en_i(b_en), .op_a_i(op_a), .op_b_i(op_b), .res_i(res), .sts_we_i(we),
    .sts_wdata_i(wdata), .out_valid_o(out_valid), .res_o(res_out), .inv_o(inv),
    .sts_o(sts)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one operation; checks outputs in the cycle after acceptance
  task automatic op(input string req, input logic d, input logic x, input logic be,
                    input logic [63:0] a, input logic [63:0] b, input logic [63:0] r,
                    input logic [63:0] exp_res, input logic exp_inv, input logic exp_flag);
    @(negedge clk);
    valid = 1; dbl = d; xfer = x; b_en = be; op_a = a; op_b = b; res = r;
    @(posedge clk); #1;
    chk({req, " valid"}, {63'b0, out_valid}, 64'd1);
    chk({req, " res"}, res_out, exp_res);
    chk({req, " inv"}, {63'b0, inv}, {63'b0, exp_inv});
    chk({req, " flag"}, {32'b0, sts}, {63'b0, exp_flag});
    @(negedge clk);
    valid = 0;
  endtask

  task automatic wr(input logic v);
    @(negedge clk);
    we = 1; wdata = {31'b0, v};
    @(negedge clk);
    we = 0;
  endtask

  task automatic t_reset;
    chk("R10 valid", {63'b0, out_valid}, 64'd0);
    chk("R10 inv", {63'b0, inv}, 64'd0);
    chk("R10 sts", {32'b0, sts}, 64'd0);
  endtask

  task automatic t_plain;
    op("R5 sp normal", 0, 0, 1, 64'h3F80_0000, 64'h4000_0000, 64'hDEAD_0000_4040_0000,
       64'h0000_0000_4040_0000, 0, 0);
    op("R5 sp inf", 0, 0, 1, 64'h7F80_0000, 64'h3F80_0000, 64'h7F80_0000,
       64'h7F80_0000, 0, 0);
    op("R5 dp inf", 1, 0, 1, 64'hFFF0_0000_0000_0000, 64'h0, 64'hFFF0_0000_0000_0000,
       64'hFFF0_0000_0000_0000, 0, 0);
    op("R1 sp upper ignored", 0, 0, 0, 64'hFFF0_0001_3F80_0000, 64'h0, 64'h1234,
       64'h1234, 0, 0);
  endtask

  task automatic t_snan;
    op("R2 sp snan", 0, 0, 0, 64'h7F80_0001, 64'h0, 64'h5555, DN_SP, 1, 1);
    op("R6 hold after valid op", 1, 0, 1, 64'h1, 64'h2, 64'h3, 64'h3, 0, 1);
    op("R6 hold after xfer", 1, 1, 0, 64'h42, 64'h0, 64'h0, 64'h42, 0, 1);
    wr(0);
    #1 chk("R7 clear", {32'b0, sts}, 64'd0);
    op("R2 dp snan on b", 1, 0, 1, 64'h4000_0000_0000_0000, 64'hFFF0_0000_0000_0007,
       64'h9, DN_DP, 1, 1);
    wr(0);
  endtask

  task automatic t_qnan;
    op("R3 dp qnan", 1, 0, 1, 64'h7FF8_0000_0000_0123, 64'h0, 64'h77, DN_DP, 0, 0);
    op("R3 sp qnan neg", 0, 0, 1, 64'h0, 64'hFFC0_0ABC, 64'h77, DN_SP, 0, 0);
  endtask

  task automatic t_xfer;
    op("R4 dp snan xfer", 1, 1, 1, 64'h7FF0_0000_0000_0005, 64'h7FF0_0000_0000_0001,
       64'h0, 64'h7FF0_0000_0000_0005, 0, 0);
    op("R4 sp qnan xfer", 0, 1, 0, 64'hAAAA_AAAA_FFC1_2345, 64'h0, 64'h0,
       64'h0000_0000_FFC1_2345, 0, 0);
  endtask

  task automatic t_bdis;
    op("R9 b snan disabled", 0, 0, 0, 64'h3F80_0000, 64'h7F80_0001, 64'h4000_0000,
       64'h4000_0000, 0, 0);
    op("R9 b qnan disabled", 1, 0, 0, 64'h1, 64'h7FF8_0000_0000_0000, 64'h8, 64'h8, 0, 0);
  endtask

  task automatic t_write;
    @(negedge clk);
    valid = 1; dbl = 0; xfer = 0; b_en = 0; op_a = 64'h7FA0_0000; res = 0;
    we = 1; wdata = 32'h0;
    @(posedge clk); #1;
    chk("R7 set beats clear", {32'b0, sts}, 64'd1);
    chk("R8 flag with strobe", {62'b0, out_valid, inv}, 64'd3);
    @(negedge clk);
    valid = 0; we = 0;
    wr(0);
    wr(1);
    #1 chk("R7 write one", {32'b0, sts}, 64'd1);
    wr(0);
    #1 chk("R7 write zero", {32'b0, sts}, 64'd0);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 t_reset();
    @(negedge clk) rst_n = 1;
    t_plain();
    t_snan();
    t_qnan();
    t_xfer();
    t_bdis();
    t_write();
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule